// File: doc/BRIEF.md
# Parallel Pseudorandom Sequence Generator for Spatial Compressive Sampling

This block drives the measurement switches of a multi-channel compressive-sampling front end. Each recording channel gets one pseudorandom bit stream. The bit a channel holds at a given step decides whether that channel's held sample is added into the shared summing node for the current measurement. Each measurement step produces a 16-bit vector, and that vector is one row of the measurement matrix. The first M vectors after a sample is held make up that sample's matrix. With M = 7, the block is stepped seven times per per-channel sample period.

Sixteen independent long registers would be costly. Instead, the block runs two short maximal-length shift registers side by side: one has 4 stages and the other has 5. Each output bit is the XOR of one stage from each register, and no two outputs use the same pair of stages. The two periods are 15 and 31, which share no factor, so the combined vector repeats only every 465 steps. The registers move only when the step input is high. A seed strobe may reload both registers at any time. An all-zero seed is replaced by that register's default seed, because a zero state would lock the register.

Top module: `cs_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the short register becomes 4'b0001 and the long register becomes 5'b00001. The output is then 16'h1116.
- R2: On a step, the 4-stage register value s becomes {s[2:0], s[3]^s[2]}. This is polynomial x^4+x^3+1, and its period is 15.
- R3: On a step, the 5-stage register value t becomes {t[3:0], t[4]^t[2]}. This is polynomial x^5+x^3+1, and its period is 31.
- R4: Output bit k (k = 0..15) is s[k mod 4] XOR t[j], where j = ((k div 4) + (1 if k mod 4 = 3, else 0)) mod 5. The output is combinational from the register state, so it changes in the cycle after a step.
- R5: When `stepEn` and `seedValid` are both low, both registers and the output keep their values.
- R6: When `seedValid` is high at a clock edge, the registers load `seedA` and `seedB`. A load takes priority over `stepEn`.
- R7: A zero value on `seedA` or `seedB` loads that register's default (4'b0001 or 5'b00001). Each register is handled on its own, and neither register ever holds zero.
- R8: After 465 steps the output vector equals its starting value. After 15 steps, and after 31 steps, it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Advance both registers one step |
| seedValid | input | 1 | Load both seeds this cycle |
| seedA | input | 4 | Seed for the 4-stage register |
| seedB | input | 5 | Seed for the 5-stage register |
| seqOut | output | 16 | One measurement-matrix row, one bit per channel |

## Verification
Some properties are checked on every cycle by the assertions. These are: both registers stay nonzero, each step is a one-place shift, state and output hold when idle, a valid nonzero seed lands in the registers, and a zero seed falls back to the default. Other behaviour can only be shown by the bench's scenarios. These are: the exact feedback bits, the stage pairing at each output, the priority of a load over a step, and the 465-step period, including the vectors that must differ at 15 and 31 steps. The bench compares every cycle against an independent model of the two recurrences and the pairing rule.

// File: rtl/cs_seq_pkg.sv
`timescale 1ns/1ps
package cs_seq_pkg;

  localparam int unsigned LEN_A   = 4;
  localparam int unsigned LEN_B   = 5;
  localparam int unsigned NUM_OUT = 16;

  localparam logic [LEN_A-1:0] TAPS_A = 4'b1100;
  localparam logic [LEN_B-1:0] TAPS_B = 5'b10100;
  localparam logic [LEN_A-1:0] DEF_A  = 4'b0001;
  localparam logic [LEN_B-1:0] DEF_B  = 5'b00001;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic advance;
    logic load;
    logic useDefA;
    logic useDefB;
  } seqCtrl_t;

endpackage

// File: rtl/cs_seq_lfsr.sv
`timescale 1ns/1ps
module cs_seq_lfsr #(
  parameter int unsigned        W    = 4,
  parameter logic [W-1:0]       TAPS = 4'b1100,
  parameter logic [W-1:0]       SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] state
);

  logic feedback;
  assign feedback = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)          state <= SEED;
    else if (load)    state <= loadVal;
    else if (advance) state <= {state[W-2:0], feedback};
  end

  // R2 / R3: a register of either length never reaches the lock-up state
  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R2 / R3: one step moves every stage up by one place
  a_r3_shift_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> state[W-1:1] == $past(state[W-2:0]));

  // R5: no strobe, no change
  a_r5_state_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load) |=> $stable(state));

endmodule

// File: rtl/cs_seq_ctrl.sv
`timescale 1ns/1ps
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int unsigned WA = LEN_A,
  parameter int unsigned WB = LEN_B
) (
  input  logic          stepEn,
  input  logic          seedValid,
  input  logic [WA-1:0] seedA,
  input  logic [WB-1:0] seedB,
  output seqCtrl_t      ctrl
);

  always_comb begin
    ctrl.load    = seedValid;
    ctrl.advance = stepEn && !seedValid;   // load wins (R6)
    ctrl.useDefA = (seedA == '0);          // R7
    ctrl.useDefB = (seedB == '0);
  end

endmodule

// File: rtl/cs_seq_datapath.sv
`timescale 1ns/1ps
module cs_seq_datapath
  import cs_seq_pkg::*;
#(
  parameter int unsigned WA   = LEN_A,
  parameter int unsigned WB   = LEN_B,
  parameter int unsigned NOUT = NUM_OUT
) (
  input  logic            clk,
  input  logic            rst,
  input  seqCtrl_t        ctrl,
  input  logic [WA-1:0]   seedA,
  input  logic [WB-1:0]   seedB,
  output logic [NOUT-1:0] seqOut
);

  logic [WA-1:0] stateA;
  logic [WB-1:0] stateB;
  logic [WA-1:0] loadA;
  logic [WB-1:0] loadB;

  assign loadA = ctrl.useDefA ? DEF_A : seedA;
  assign loadB = ctrl.useDefB ? DEF_B : seedB;

  cs_seq_lfsr #(.W(WA), .TAPS(TAPS_A), .SEED(DEF_A)) i_regA (
    .clk(clk), .rst(rst), .advance(ctrl.advance), .load(ctrl.load),
    .loadVal(loadA), .state(stateA)
  );

  cs_seq_lfsr #(.W(WB), .TAPS(TAPS_B), .SEED(DEF_B)) i_regB (
    .clk(clk), .rst(rst), .advance(ctrl.advance), .load(ctrl.load),
    .loadVal(loadB), .state(stateB)
  );

  // Distinct stage pairing per output channel
  for (genvar k = 0; k < NOUT; k++) begin : g_pair
    localparam int unsigned IDX_A = k % WA;
    localparam int unsigned IDX_B = ((k / WA) + ((IDX_A == WA - 1) ? 1 : 0)) % WB;
    assign seqOut[k] = stateA[IDX_A] ^ stateB[IDX_B];
  end

  // R5: output vector holds while idle
  a_r5_out_stable: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.advance && !ctrl.load) |=> $stable(seqOut));

  // R6: a nonzero seed is taken as given
  a_r6_seed_load: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && seedA != '0 && seedB != '0) |=>
      (stateA == $past(seedA) && stateB == $past(seedB)));

  // R7: zero seed falls back to default, per register
  a_r7_zero_seed_a: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && seedA == '0) |=> stateA == DEF_A);
  a_r7_zero_seed_b: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && seedB == '0) |=> stateB == DEF_B);

endmodule

// File: rtl/cs_seq_gen.sv
`timescale 1ns/1ps
module cs_seq_gen
  import cs_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stepEn,
  input  logic               seedValid,
  input  logic [LEN_A-1:0]   seedA,
  input  logic [LEN_B-1:0]   seedB,
  output logic [NUM_OUT-1:0] seqOut
);

  seqCtrl_t ctrl;

  cs_seq_ctrl #(.WA(LEN_A), .WB(LEN_B)) i_ctrl (
    .stepEn(stepEn), .seedValid(seedValid),
    .seedA(seedA), .seedB(seedB), .ctrl(ctrl)
  );

  cs_seq_datapath #(.WA(LEN_A), .WB(LEN_B), .NOUT(NUM_OUT)) i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .seedA(seedA), .seedB(seedB), .seqOut(seqOut)
  );

endmodule

// File: tb/test_cs_seq_gen.sv
`timescale 1ns/1ps
module test_cs_seq_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        stepEn;
  logic        seedValid;
  logic [3:0]  seedA;
  logic [4:0]  seedB;
  logic [15:0] seqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_seq_gen i_cs_seq_gen (
    .clk(clk), .rst(rst), .stepEn(stepEn), .seedValid(seedValid),
    .seedA(seedA), .seedB(seedB), .seqOut(seqOut)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  logic [3:0] mdlA;
  logic [4:0] mdlB;

  function automatic logic [3:0] stepA(logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  function automatic logic [4:0] stepB(logic [4:0] t);
    return {t[3:0], t[4] ^ t[2]};
  endfunction

  function automatic logic [15:0] mapOut(logic [3:0] s, logic [4:0] t);
    logic [15:0] v;
    for (int k = 0; k < 16; k++) begin
      int j;
      j = ((k / 4) + ((k % 4) == 3 ? 1 : 0)) % 5;
      v[k] = s[k % 4] ^ t[j];
    end
    return v;
  endfunction

  // Driver: apply one cycle of stimulus, advance the model, queue expectation
  task automatic drive(input logic r, input logic st, input logic sv,
                       input logic [3:0] sa, input logic [4:0] sb, input string tag);
    rst = r; stepEn = st; seedValid = sv; seedA = sa; seedB = sb;
    if (r) begin
      mdlA = 4'b0001; mdlB = 5'b00001;
    end else if (sv) begin
      mdlA = (sa == 4'd0) ? 4'b0001 : sa;
      mdlB = (sb == 5'd0) ? 5'b00001 : sb;
    end else if (st) begin
      mdlA = stepA(mdlA); mdlB = stepB(mdlB);
    end
    q.push_back('{mapOut(mdlA, mdlB), tag});
    @(negedge clk);
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input bit wantEq, input string tag);
    checks++;
    if ((act == exp) != wantEq) begin
      errors++;
      $display("FAIL %s: actual=%h expected %s%h", tag, act, wantEq ? "" : "not ", exp);
    end
  endtask

  // Monitor: sample after each rising edge and compare
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(seqOut, it.exp, 1'b1, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] start;
    rst = 1'b1; stepEn = 1'b0; seedValid = 1'b0; seedA = '0; seedB = '0;
    @(negedge clk);
    // R1: reset state
    drive(1, 0, 0, 4'd0, 5'd0, "R1 reset");
    drive(1, 1, 0, 4'd0, 5'd0, "R1 reset");
    check(seqOut, 16'h1116, 1'b1, "R1 reset vector");
    // R2 R3 R4: stepping from reset
    for (int i = 0; i < 20; i++) drive(0, 1, 0, 4'd0, 5'd0, "R4 step");
    // R5: idle hold
    for (int i = 0; i < 5; i++) drive(0, 0, 0, 4'hF, 5'h1F, "R5 hold");
    // R6: load beats step
    drive(0, 1, 1, 4'b1010, 5'b01101, "R6 load priority");
    for (int i = 0; i < 6; i++) drive(0, 1, 0, 4'd0, 5'd0, "R2 step after load");
    // R7: zero seeds
    drive(0, 0, 1, 4'd0, 5'b10011, "R7 zero seedA");
    drive(0, 1, 0, 4'd0, 5'd0, "R3 step");
    drive(0, 0, 1, 4'b0110, 5'd0, "R7 zero seedB");
    drive(0, 1, 0, 4'd0, 5'd0, "R2 step");
    drive(0, 1, 1, 4'd0, 5'd0, "R7 both zero");
    check(seqOut, 16'h1116, 1'b1, "R7 both zero default vector");
    // R8: period 465, not 15 or 31
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 4'd0, 5'd0, "R4 step");
    start = seqOut;
    for (int i = 0; i < 15; i++) drive(0, 1, 0, 4'd0, 5'd0, "R2 period");
    check(seqOut, start, 1'b0, "R8 differs after 15");
    for (int i = 0; i < 16; i++) drive(0, 1, 0, 4'd0, 5'd0, "R3 period");
    check(seqOut, start, 1'b0, "R8 differs after 31");
    for (int i = 0; i < 465 - 31; i++) drive(0, 1, 0, 4'd0, 5'd0, "R4 period");
    check(seqOut, start, 1'b1, "R8 equal after 465");
    stepEn = 1'b0;
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R4: actual=%0d pending expected=0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule